// File: doc/BRIEF.md
# Per-Peripheral Interrupt Aggregator

This block gathers interrupt events raised by the peripherals of a power-management bus and presents them to software. Each peripheral has a small identifier of 8 bits. An upstream bus decoder delivers events as single-cycle pulses. Each pulse carries one identifier and an 8-bit mask of interrupt bits. The block keeps 8 sticky status bits, an enable bit and an owner field for every peripheral. It folds all of this into packed summary words, one set of words for each owner, and drives a single active-high, level-sensitive interrupt line for the owner that this instance serves.

Software services the line in three steps. It scans the summary words of its owner. It reads the status of each flagged peripheral. It then writes the bits it has handled to that peripheral's clear register. Disabling a peripheral hides it from the summary words and from the line, but its status bits are kept. When the peripheral is enabled again, any pending bits show up at once.

The output line is driven by a two-state machine.
- States: `LINE_QUIET` and `LINE_RAISED`.
- Transition "raise" (`LINE_QUIET` to `LINE_RAISED`) is taken at the clock edge where a pending source exists.
- Transition "drop" (`LINE_RAISED` to `LINE_QUIET`) is taken at the edge where no pending source is left.

Top module: `periph_irq_agg`

## Requirements
- R1: After reset, every status, enable and owner field is zero, every register reads zero, and `irq_o` is low.
- R2: A pulse on `req_valid` whose `req_id` is below NUM_PERIPH ORs `req_mask` into that peripheral's status. The status reads back in bits [7:0] at byte address 0x600 + 4·ID. A pulse whose ID is NUM_PERIPH or above changes nothing.
- R3: A write to byte address 0xA00 + 4·ID clears the status bits of that peripheral that are set in `reg_wdata[7:0]`. All other status bits are kept. This clear region always reads zero.
- R4: When a request and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Byte address 0x200 + 4·ID holds the enable in bit 0 and the owner in bits [8 +: OWN_W]. A read returns the written fields, and every other bit reads zero.
- R6: The summary word at byte address 32·M + 4·N has bit j set exactly when peripheral 32·N + j is enabled, has owner M and has nonzero status. A word with M ≥ NUM_OWNERS or N ≥ NUM_PERIPH/32 reads zero.
- R7: `irq_o` is high in the cycle after any clock edge that sees at least one enabled peripheral with owner HOST_OWNER and nonzero status. It is low in the cycle after any edge that sees none.
- R8: Clearing the enable bit keeps the peripheral's status bits unchanged. Setting the enable bit again brings the peripheral back into the summary and onto the line.
- R9: Writes to the status region (0x600 + 4·ID) change no state.
- R10: A status bit that is set stays set until a clear write to its own peripheral removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Single-cycle interrupt event from the bus decoder |
| req_id | input | 8 | Peripheral identifier of the event |
| req_mask | input | 8 | Interrupt bits raised by the event |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address, used for both reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level-high interrupt line for HOST_OWNER |

## Verification
The bound checker watches three properties on every cycle. It checks that a nonzero request always leaves its peripheral holding status, which also covers the case where a clear hits the same bit. It checks that status never vanishes without a clear write to that same peripheral. It checks that the line follows the host-owner pending condition with exactly one cycle of lag.

The bench alone covers the register map as software sees it:
- the enable and owner readback fields;
- the packing of bits into the summary words for every owner and group, including the words that are out of range;
- partial clears and writes to the read-only status region;
- out-of-range request IDs;
- keeping status across a disable and re-enable.

Both random and directed traffic are compared against a reference model of the register file.

// File: rtl/pia_pkg.sv
`timescale 1ns/1ps
package pia_pkg;
    localparam int ID_W       = 8;
    localparam int STAT_W     = 8;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int GROUP_SIZE = 32;

    localparam logic [ADDR_W-1:0] EN_BASE   = 12'h200;
    localparam logic [ADDR_W-1:0] STAT_BASE = 12'h600;
    localparam logic [ADDR_W-1:0] CLR_BASE  = 12'hA00;
    localparam logic [ADDR_W-1:0] CLR_END   = 12'hE00;

    typedef enum logic [2:0] {
        RGN_ACC,
        RGN_EN,
        RGN_STAT,
        RGN_CLR,
        RGN_NONE
    } region_e;

    typedef struct packed {
        region_e           rgn;
        logic [ID_W-1:0]   idx;
    } decode_t;

    typedef enum logic {
        LINE_QUIET,
        LINE_RAISED
    } line_state_e;

    // Split a byte address into its region and the word index inside it.
    function automatic decode_t decode_addr(input logic [ADDR_W-1:0] a);
        decode_t           d;
        logic [ADDR_W-1:0] off;
        d.rgn = RGN_NONE;
        off   = '0;
        if (a < EN_BASE) begin
            d.rgn = RGN_ACC;
            off   = a;
        end else if (a < STAT_BASE) begin
            d.rgn = RGN_EN;
            off   = a - EN_BASE;
        end else if (a < CLR_BASE) begin
            d.rgn = RGN_STAT;
            off   = a - STAT_BASE;
        end else if (a < CLR_END) begin
            d.rgn = RGN_CLR;
            off   = a - CLR_BASE;
        end
        d.idx = off[ID_W+1:2];
        return d;
    endfunction
endpackage

// File: rtl/pia_slot.sv
`timescale 1ns/1ps
module pia_slot
    import pia_pkg::*;
#(
    parameter int OWN_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_bit,
    input  logic [OWN_W-1:0]  own_bits,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_mask,
    input  logic              req_hit,
    input  logic [STAT_W-1:0] req_mask,
    output logic              en_o,
    output logic [OWN_W-1:0]  own_o,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] clr_bits;
    logic [STAT_W-1:0] set_bits;
    logic [STAT_W-1:0] stat_q;
    logic              en_q;
    logic [OWN_W-1:0]  own_q;

    always_comb begin
        clr_bits = clr_wr  ? clr_mask : '0;
        set_bits = req_hit ? req_mask : '0;
    end

    // The set term is applied after the clear term, so a new event is never lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= 1'b0;
            own_q  <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | set_bits;
            if (en_wr) begin
                en_q  <= en_bit;
                own_q <= own_bits;
            end
        end
    end

    assign en_o   = en_q;
    assign own_o  = own_q;
    assign stat_o = stat_q;
endmodule

// File: rtl/pia_summary.sv
`timescale 1ns/1ps
module pia_summary
    import pia_pkg::*;
#(
    parameter int NUM_PERIPH = 64,
    parameter int NUM_OWNERS = 4,
    parameter int HOST_OWNER = 0,
    parameter int OWN_W      = 2,
    parameter int NUM_GROUPS = 2
) (
    input  logic [NUM_PERIPH-1:0]                                en_i,
    input  logic [NUM_PERIPH-1:0][OWN_W-1:0]                     own_i,
    input  logic [NUM_PERIPH-1:0]                                stat_any_i,
    output logic [NUM_OWNERS-1:0][NUM_GROUPS-1:0][GROUP_SIZE-1:0] acc_o,
    output logic                                                 host_pending_o
);
    logic [NUM_PERIPH-1:0] live;
    logic [NUM_PERIPH-1:0] host_live;

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_live
        assign live[i]      = en_i[i] & stat_any_i[i];
        assign host_live[i] = live[i] & (own_i[i] == OWN_W'(HOST_OWNER));
    end

    for (genvar m = 0; m < NUM_OWNERS; m++) begin : g_owner
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
            for (genvar j = 0; j < GROUP_SIZE; j++) begin : g_bit
                assign acc_o[m][g][j] = live[g*GROUP_SIZE+j]
                                      & (own_i[g*GROUP_SIZE+j] == OWN_W'(m));
            end
        end
    end

    assign host_pending_o = |host_live;
endmodule

// File: rtl/pia_line_fsm.sv
`timescale 1ns/1ps
module pia_line_fsm
    import pia_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_o
);
    line_state_e state_q;
    line_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINE_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINE_QUIET:  if (pending_i)  state_d = LINE_RAISED;  // raise
            LINE_RAISED: if (!pending_i) state_d = LINE_QUIET;   // drop
            default:                     state_d = LINE_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == LINE_RAISED);
    end
endmodule

// File: rtl/periph_irq_agg.sv
`timescale 1ns/1ps
module periph_irq_agg
    import pia_pkg::*;
#(
    parameter int NUM_PERIPH = 64,
    parameter int NUM_OWNERS = 4,
    parameter int HOST_OWNER = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   req_id,
    input  logic [STAT_W-1:0] req_mask,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o
);
    localparam int OWN_W      = (NUM_OWNERS > 1) ? $clog2(NUM_OWNERS) : 1;
    localparam int NUM_GROUPS = NUM_PERIPH / GROUP_SIZE;

    decode_t                                                dec;
    logic [NUM_PERIPH-1:0]                                  en_wr;
    logic [NUM_PERIPH-1:0]                                  clr_wr;
    logic [NUM_PERIPH-1:0]                                  req_hit;
    logic [NUM_PERIPH-1:0]                                  en_q;
    logic [NUM_PERIPH-1:0][OWN_W-1:0]                       own_q;
    logic [NUM_PERIPH-1:0][STAT_W-1:0]                      stat_q;
    logic [NUM_PERIPH-1:0]                                  stat_any;
    logic [NUM_OWNERS-1:0][NUM_GROUPS-1:0][GROUP_SIZE-1:0]  acc;
    logic                                                   host_pending;
    logic                                                   unused_bits;

    assign dec         = decode_addr(reg_addr);
    assign unused_bits = ^{reg_wdata[DATA_W-1:8+OWN_W], reg_addr[1:0]};

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_slot
        assign en_wr[i]   = reg_wr_en && (dec.rgn == RGN_EN)  && (dec.idx == ID_W'(i));
        assign clr_wr[i]  = reg_wr_en && (dec.rgn == RGN_CLR) && (dec.idx == ID_W'(i));
        assign req_hit[i] = req_valid && (req_id == ID_W'(i));
        assign stat_any[i] = |stat_q[i];

        pia_slot #(.OWN_W(OWN_W)) slot_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_wr    (en_wr[i]),
            .en_bit   (reg_wdata[0]),
            .own_bits (reg_wdata[8 +: OWN_W]),
            .clr_wr   (clr_wr[i]),
            .clr_mask (reg_wdata[STAT_W-1:0]),
            .req_hit  (req_hit[i]),
            .req_mask (req_mask),
            .en_o     (en_q[i]),
            .own_o    (own_q[i]),
            .stat_o   (stat_q[i])
        );
    end

    pia_summary #(
        .NUM_PERIPH (NUM_PERIPH),
        .NUM_OWNERS (NUM_OWNERS),
        .HOST_OWNER (HOST_OWNER),
        .OWN_W      (OWN_W),
        .NUM_GROUPS (NUM_GROUPS)
    ) summary_i (
        .en_i           (en_q),
        .own_i          (own_q),
        .stat_any_i     (stat_any),
        .acc_o          (acc),
        .host_pending_o (host_pending)
    );

    pia_line_fsm line_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (host_pending),
        .irq_o     (irq_o)
    );

    // Combinational read port.
    always_comb begin
        reg_rdata = '0;
        unique case (dec.rgn)
            RGN_ACC: begin
                for (int m = 0; m < NUM_OWNERS; m++) begin
                    for (int g = 0; g < NUM_GROUPS; g++) begin
                        if (dec.idx[6:3] == 4'(m) && dec.idx[2:0] == 3'(g)) begin
                            reg_rdata = acc[m][g];
                        end
                    end
                end
            end
            RGN_EN: begin
                for (int i = 0; i < NUM_PERIPH; i++) begin
                    if (dec.idx == ID_W'(i)) begin
                        reg_rdata[0]          = en_q[i];
                        reg_rdata[8 +: OWN_W] = own_q[i];
                    end
                end
            end
            RGN_STAT: begin
                for (int i = 0; i < NUM_PERIPH; i++) begin
                    if (dec.idx == ID_W'(i)) reg_rdata[STAT_W-1:0] = stat_q[i];
                end
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pia_checker.sv
`timescale 1ns/1ps
module pia_checker
    import pia_pkg::*;
#(
    parameter int NUM_PERIPH = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [ID_W-1:0]       req_id,
    input logic [STAT_W-1:0]     req_mask,
    input logic                  reg_wr_en,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  irq_o,
    input logic                  host_pending,
    input logic [NUM_PERIPH-1:0] slot_any
);
    logic unused_chk;
    assign unused_chk = ^reg_addr[1:0];

    for (genvar i = 0; i < NUM_PERIPH; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] CLR_A = CLR_BASE + ADDR_W'(4*i);

        // R2 and R4: a nonzero event always leaves status behind, even when a clear collides.
        p_req_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_id == ID_W'(i) && req_mask != '0) |=> slot_any[i]);

        // R10: status only vanishes through a clear write to the same peripheral.
        p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_any[i] && !(reg_wr_en && reg_addr[ADDR_W-1:2] == CLR_A[ADDR_W-1:2]))
            |=> slot_any[i]);
    end

    p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_pending |=> irq_o);

    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !host_pending |=> !irq_o);

    p_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        host_pending |-> (slot_any != '0));
endmodule

bind periph_irq_agg pia_checker #(.NUM_PERIPH(NUM_PERIPH)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_id       (req_id),
    .req_mask     (req_mask),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .irq_o        (irq_o),
    .host_pending (host_pending),
    .slot_any     (stat_any)
);

// File: tb/periph_irq_agg_tb_top.sv
`timescale 1ns/1ps
module periph_irq_agg_tb_top;
    localparam int NP   = 64;
    localparam int NO   = 4;
    localparam int HOST = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_id = '0;
    logic [7:0]  req_mask = '0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    bit        m_en   [NP];
    bit [1:0]  m_own  [NP];
    bit [7:0]  m_stat [NP];
    bit        m_irq  = 1'b0;

    always #2 clk = ~clk;

    periph_irq_agg #(.NUM_PERIPH(NP), .NUM_OWNERS(NO), .HOST_OWNER(HOST)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_mask(req_mask), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic bit model_pending();
        bit p = 1'b0;
        for (int i = 0; i < NP; i++)
            if (m_en[i] && int'(m_own[i]) == HOST && m_stat[i] != 0) p = 1'b1;
        return p;
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        logic [31:0] r = '0;
        int id, m, n;
        if (a < 12'h200) begin
            m = int'(a[8:5]);
            n = int'(a[4:2]);
            if (m < NO && n < NP/32)
                for (int j = 0; j < 32; j++)
                    r[j] = m_en[32*n+j] && int'(m_own[32*n+j]) == m && m_stat[32*n+j] != 0;
        end else if (a < 12'h600) begin
            id = int'((a - 12'h200) >> 2);
            if (id < NP) begin r[0] = m_en[id]; r[9:8] = m_own[id]; end
        end else if (a < 12'hA00) begin
            id = int'((a - 12'h600) >> 2);
            if (id < NP) r[7:0] = m_stat[id];
        end
        return r;
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_edge();
        bit p;
        p = model_pending();
        @(posedge clk);
        m_irq = p;
        @(negedge clk);
    endtask

    // One clock edge with optional register write and event pulse.
    task automatic do_cycle(input bit wr, input logic [11:0] a, input logic [31:0] wd,
                            input bit rv, input logic [7:0] rid, input logic [7:0] rm);
        bit p;
        int id;
        reg_wr_en = wr; reg_addr = a; reg_wdata = wd;
        req_valid = rv; req_id = rid; req_mask = rm;
        p = model_pending();
        @(posedge clk);
        m_irq = p;
        if (wr) begin
            if (a >= 12'hA00 && a < 12'hE00) begin
                id = int'((a - 12'hA00) >> 2);
                if (id < NP) m_stat[id] &= ~wd[7:0];
            end else if (a >= 12'h200 && a < 12'h600) begin
                id = int'((a - 12'h200) >> 2);
                if (id < NP) begin m_en[id] = wd[0]; m_own[id] = wd[9:8]; end
            end
        end
        if (rv && int'(rid) < NP) m_stat[rid] |= rm;
        @(negedge clk);
        reg_wr_en = 1'b0; req_valid = 1'b0;
    endtask

    task automatic read_check(input logic [11:0] a, input string tag);
        reg_wr_en = 1'b0; req_valid = 1'b0; reg_addr = a;
        #1;
        chk(reg_rdata, exp_read(a), tag);
        idle_edge();
    endtask

    task automatic irq_check(input string tag);
        chk({31'b0, irq_o}, {31'b0, m_irq}, tag);
    endtask

    function automatic logic [11:0] en_a(input int id);  return 12'h200 + 12'(4*id); endfunction
    function automatic logic [11:0] st_a(input int id);  return 12'h600 + 12'(4*id); endfunction
    function automatic logic [11:0] cl_a(input int id);  return 12'hA00 + 12'(4*id); endfunction
    function automatic logic [11:0] acc_a(input int m, input int n); return 12'(32*m + 4*n); endfunction

    initial begin
        #(4*150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] a;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        irq_check("R1 irq after reset");
        read_check(acc_a(0, 0), "R1 summary reset");
        read_check(en_a(3), "R1 enable reset");
        read_check(st_a(63), "R1 status reset");

        // R5: enable and owner readback
        do_cycle(1, en_a(5), 32'hFFFF_F001, 0, 0, 0);
        read_check(en_a(5), "R5 enable readback");

        // R2: event sets status; R7: line follows one edge later
        do_cycle(0, 0, 0, 1, 8'd5, 8'h81);
        irq_check("R7 irq not yet high");
        read_check(st_a(5), "R2 status set");
        irq_check("R7 irq raised");
        read_check(acc_a(0, 0), "R6 summary bit owner0");

        // R3: partial clear
        do_cycle(1, cl_a(5), 32'h0000_0001, 0, 0, 0);
        read_check(st_a(5), "R3 partial clear");
        read_check(cl_a(5), "R3 clear region reads zero");

        // R4: collision of event and clear
        do_cycle(1, cl_a(5), 32'h0000_0082, 1, 8'd5, 8'h02);
        read_check(st_a(5), "R4 event wins over clear");

        // R9: status region is read-only
        do_cycle(1, st_a(5), 32'h0000_00FF, 0, 0, 0);
        read_check(st_a(5), "R9 status write ignored");

        // R8: disable keeps status and drops the line
        do_cycle(1, en_a(5), 32'h0, 0, 0, 0);
        read_check(st_a(5), "R8 status kept when disabled");
        read_check(acc_a(0, 0), "R8 summary masked");
        irq_check("R8 irq dropped");
        do_cycle(1, en_a(5), 32'h1, 0, 0, 0);
        read_check(acc_a(0, 0), "R8 summary restored");
        irq_check("R8 irq back");

        // R2: out-of-range ID is ignored
        do_cycle(0, 0, 0, 1, 8'd200, 8'hFF);
        for (int i = 0; i < NP; i++) read_check(st_a(i), "R2 out-of-range id");

        // R6: foreign owner, out-of-range summary words
        do_cycle(1, en_a(40), 32'h0000_0201, 1, 8'd40, 8'h10);
        read_check(acc_a(2, 1), "R6 owner2 group1");
        read_check(acc_a(0, 1), "R6 owner0 group1 excludes owner2");
        read_check(acc_a(5, 0), "R6 owner beyond range");
        read_check(acc_a(1, 3), "R6 group beyond range");
        irq_check("R7 foreign owner no effect");

        // R10: clear of one peripheral leaves others alone
        do_cycle(1, cl_a(6), 32'hFF, 0, 0, 0);
        read_check(st_a(5), "R10 sticky");

        // Random traffic
        for (int it = 0; it < 600; it++) begin
            int op = int'($urandom % 4);
            int id = int'($urandom % NP);
            logic [31:0] wd = $urandom;
            logic [7:0]  rid = 8'($urandom % 80);
            bit rv = bit'($urandom % 2);
            case (op)
                0: do_cycle(1, cl_a(id), wd, rv, rid, 8'($urandom));
                1: do_cycle(1, en_a(id), wd, rv, rid, 8'($urandom));
                2: do_cycle(1, st_a(id), wd, rv, rid, 8'($urandom));
                default: do_cycle(0, 0, 0, 1, rid, 8'($urandom));
            endcase
            irq_check("R7 random irq");
            case ($urandom % 4)
                0: a = 12'(($urandom % 128) * 4);
                1: a = en_a(int'($urandom % 256));
                2: a = st_a(int'($urandom % 256));
                default: a = cl_a(int'($urandom % 256));
            endcase
            read_check(a, "R6 random read");
        end
        for (int i = 0; i < NP; i++) begin
            read_check(en_a(i), "R5 final enable sweep");
            read_check(st_a(i), "R10 final status sweep");
        end
        for (int m = 0; m < 8; m++)
            for (int n = 0; n < 4; n++) read_check(acc_a(m, n), "R6 final summary sweep");
        irq_check("R7 final irq");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule